// File: doc/BRIEF.md
# Load/Store Address Generator

This unit turns the address fields of a memory instruction into a finished byte address. It also produces the updated base-register value for the forms that modify the base. Each cycle it samples a base value, a 12-bit signed displacement, an index value, a 2-bit scale and a 2-bit mode. One clock edge later, it presents a registered address, a registered next-base value, a write-back strobe and a valid flag. It sits in the execute stage, so the memory stage that follows gets a ready address and needs no extra cycle.

Four forms are supported:
- **Offset:** base plus displacement, with the base left alone.
- **Pre-update:** the address is base plus displacement, and that same sum goes back to the base.
- **Post-update:** the address is the untouched base, and base plus displacement goes back to the base.
- **Scaled index:** the address is base plus the index shifted left by 0 to 3 places, with no base update.

Top module: `ld_st_agu`

## Requirements
- R1: While `rst_n` is low at a rising edge, `out_valid`, `base_wr_en`, `mem_addr` and `new_base` are all zero after that edge.
- R2: With `mode_sel` = 2'b00 (offset), `mem_addr` = base + extended displacement, `new_base` = base, and `base_wr_en` = 0.
- R3: With `mode_sel` = 2'b01 (pre-update), `mem_addr` and `new_base` both equal base + extended displacement, and `base_wr_en` = 1.
- R4: With `mode_sel` = 2'b10 (post-update), `mem_addr` = base, `new_base` = base + extended displacement, and `base_wr_en` = 1.
- R5: With `mode_sel` = 2'b11 (scaled index), `mem_addr` = base + (index << `scale_sel`) for `scale_sel` 0..3 (factors 1, 2, 4, 8), `new_base` = base, and `base_wr_en` = 0.
- R6: `disp_imm` is a 12-bit two's-complement value (12'h800 = -2048, 12'hFFF = -1), sign-extended to 32 bits before the add.
- R7: All sums wrap modulo 2^32; no overflow indication exists.
- R8: Inputs sampled with `in_valid` high at one rising edge appear on the outputs right after that edge with `out_valid` high. Consecutive valid cycles give consecutive results.
- R9: After an edge with `in_valid` low, `out_valid` and `base_wr_en` are 0, and `mem_addr` and `new_base` keep their previous values whatever the other inputs are.
- R10: `index_val` and `scale_sel` have no effect in modes 00, 01 and 10. `disp_imm` has no effect in mode 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request qualifier |
| mode_sel | input | 2 | 00 offset, 01 pre-update, 10 post-update, 11 scaled index |
| base_val | input | 32 | Base register value |
| disp_imm | input | 12 | Signed displacement |
| index_val | input | 32 | Index register value |
| scale_sel | input | 2 | Left-shift amount for the index |
| out_valid | output | 1 | Registered result valid |
| mem_addr | output | 32 | Effective access address |
| new_base | output | 32 | Next base value |
| base_wr_en | output | 1 | Base write-back strobe |

## Verification
The hardest situation to reach is one where a wrong field leaks into the sum. A stray index in a displacement mode, or a displacement in the scaled mode, only shows up if that field carries a large, distinctive value at the same moment. The directed tasks therefore load the ignored field with all-ones or other large values while the used fields stay small. Wrap-around is forced with bases near 2^32 and a negative 12'h800 displacement. Hold behaviour is reached by dropping `in_valid` while every other input changes to fresh values.

// File: rtl/agu_pkg.sv
// agu_pkg: shared types for the address generator.
// Assumes a 2-bit mode field whose encoding is fixed by instruction decode.
package agu_pkg;

    typedef enum logic [1:0] {
        AGU_OFFSET = 2'b00,
        AGU_PRE    = 2'b01,
        AGU_POST   = 2'b10,
        AGU_SCALED = 2'b11
    } agu_mode_e;

endpackage

// File: rtl/agu_disp_ext.sv
// agu_disp_ext: sign-extends a narrow two's-complement displacement to the
// datapath width. Assumes DISP_W <= XLEN.
module agu_disp_ext #(
    parameter int DISP_W = 12,
    parameter int XLEN   = 32
) (
    input  logic [DISP_W-1:0] disp_in,
    output logic [XLEN-1:0]   disp_ext
);
    localparam int PAD_W = XLEN - DISP_W;

    // Replicate the displacement sign bit into the upper bits.
    always_comb begin
        disp_ext = {{PAD_W{disp_in[DISP_W-1]}}, disp_in};
    end
endmodule

// File: rtl/agu_index_scale.sv
// agu_index_scale: left-shifts the index by a small selectable amount.
// Assumes the shift field is narrow; one fixed shift per code is built and
// muxed, so no barrel shifter is inferred.
module agu_index_scale #(
    parameter int XLEN    = 32,
    parameter int SHAMT_W = 2
) (
    input  logic [XLEN-1:0]    index_in,
    input  logic [SHAMT_W-1:0] shamt,
    output logic [XLEN-1:0]    index_scaled
);
    localparam int N_SHIFT = 1 << SHAMT_W;

    logic [XLEN-1:0] shifted [N_SHIFT];

    for (genvar s = 0; s < N_SHIFT; s++) begin : g_shift
        // Fixed-distance shift for code s.
        assign shifted[s] = index_in << s;
    end

    // Pick the shifted copy named by the shift field.
    always_comb begin
        index_scaled = shifted[shamt];
    end
endmodule

// File: rtl/agu_calc.sv
// agu_calc: combinational core. Forms the base+displacement and
// base+scaled-index sums and routes them by mode to address, next base and
// write-back. Assumes operands are already extended/scaled; sums wrap.
module agu_calc #(
    parameter int XLEN = 32
) (
    input  agu_pkg::agu_mode_e mode,
    input  logic [XLEN-1:0]    base,
    input  logic [XLEN-1:0]    disp_ext,
    input  logic [XLEN-1:0]    index_scaled,
    output logic [XLEN-1:0]    addr,
    output logic [XLEN-1:0]    next_base,
    output logic               wb
);
    import agu_pkg::*;

    logic [XLEN-1:0] sum_disp;
    logic [XLEN-1:0] sum_index;

    // Two independent adders so the mode mux sits after both sums.
    always_comb begin
        sum_disp  = base + disp_ext;
        sum_index = base + index_scaled;
    end

    // Route sums to the outputs according to the addressing form.
    always_comb begin
        addr      = sum_disp;
        next_base = base;
        wb        = 1'b0;
        unique case (mode)
            AGU_OFFSET: begin
                addr = sum_disp;
            end
            AGU_PRE: begin
                addr      = sum_disp;
                next_base = sum_disp;
                wb        = 1'b1;
            end
            AGU_POST: begin
                addr      = base;
                next_base = sum_disp;
                wb        = 1'b1;
            end
            AGU_SCALED: begin
                addr = sum_index;
            end
            default: begin
                addr = sum_disp;
            end
        endcase
    end
endmodule

// File: rtl/ld_st_agu.sv
// ld_st_agu: one-stage address generator for memory instructions.
// Registers the effective address, the next base value and a write-back
// strobe one edge after a valid request. Assumes a synchronous active-low
// reset and that decode supplies mode and fields already separated.
module ld_st_agu #(
    parameter int XLEN    = 32,
    parameter int DISP_W  = 12,
    parameter int SHAMT_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [1:0]         mode_sel,
    input  logic [XLEN-1:0]    base_val,
    input  logic [DISP_W-1:0]  disp_imm,
    input  logic [XLEN-1:0]    index_val,
    input  logic [SHAMT_W-1:0] scale_sel,
    output logic               out_valid,
    output logic [XLEN-1:0]    mem_addr,
    output logic [XLEN-1:0]    new_base,
    output logic               base_wr_en
);
    import agu_pkg::*;

    logic [XLEN-1:0] disp_ext;
    logic [XLEN-1:0] index_scaled;
    logic [XLEN-1:0] addr_c;
    logic [XLEN-1:0] nbase_c;
    logic            wb_c;
    agu_mode_e       mode_e;

    // Interpret the raw mode bits as the addressing-form enum.
    always_comb begin
        mode_e = agu_mode_e'(mode_sel);
    end

    agu_disp_ext #(
        .DISP_W (DISP_W),
        .XLEN   (XLEN)
    ) disp_ext_i (
        .disp_in  (disp_imm),
        .disp_ext (disp_ext)
    );

    agu_index_scale #(
        .XLEN    (XLEN),
        .SHAMT_W (SHAMT_W)
    ) index_scale_i (
        .index_in     (index_val),
        .shamt        (scale_sel),
        .index_scaled (index_scaled)
    );

    agu_calc #(
        .XLEN (XLEN)
    ) calc_i (
        .mode         (mode_e),
        .base         (base_val),
        .disp_ext     (disp_ext),
        .index_scaled (index_scaled),
        .addr         (addr_c),
        .next_base    (nbase_c),
        .wb           (wb_c)
    );

    // Output stage: qualifiers every cycle, data only on a valid request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            base_wr_en <= 1'b0;
            mem_addr   <= '0;
            new_base   <= '0;
        end else begin
            out_valid  <= in_valid;
            base_wr_en <= in_valid & wb_c;
            if (in_valid) begin
                mem_addr <= addr_c;
                new_base <= nbase_c;
            end
        end
    end

    // R8
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !base_wr_en));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(mem_addr) && $stable(new_base)));

    // R2
    offset_base_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_sel == 2'b00) |=> (new_base == $past(base_val) && !base_wr_en));

    // R3
    pre_addr_eq_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_sel == 2'b01) |=> (mem_addr == new_base && base_wr_en));

    // R4
    post_addr_orig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_sel == 2'b10) |=> (mem_addr == $past(base_val) && base_wr_en));

    // R5
    scaled_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_sel == 2'b11) |=> (!base_wr_en && new_base == $past(base_val)));

    // R8
    wb_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        base_wr_en |-> out_valid);
endmodule

// File: tb/ld_st_agu_tb_top.sv
module ld_st_agu_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [1:0]  mode_sel;
    logic [31:0] base_val;
    logic [11:0] disp_imm;
    logic [31:0] index_val;
    logic [1:0]  scale_sel;
    logic        out_valid;
    logic [31:0] mem_addr;
    logic [31:0] new_base;
    logic        base_wr_en;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    ld_st_agu dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .mode_sel   (mode_sel),
        .base_val   (base_val),
        .disp_imm   (disp_imm),
        .index_val  (index_val),
        .scale_sel  (scale_sel),
        .out_valid  (out_valid),
        .mem_addr   (mem_addr),
        .new_base   (new_base),
        .base_wr_en (base_wr_en)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] sx(input logic [11:0] d);
        return {{20{d[11]}}, d};
    endfunction

    // Drive one valid request, then check the result right after the next edge.
    task automatic run_op(input string req, input logic [1:0] m, input logic [31:0] b,
                          input logic [11:0] d, input logic [31:0] ix, input logic [1:0] sh);
        logic [31:0] ea, nb;
        logic        wb;
        case (m)
            2'b00:   begin ea = b + sx(d);        nb = b;         wb = 1'b0; end
            2'b01:   begin ea = b + sx(d);        nb = b + sx(d); wb = 1'b1; end
            2'b10:   begin ea = b;                nb = b + sx(d); wb = 1'b1; end
            default: begin ea = b + (ix << sh);   nb = b;         wb = 1'b0; end
        endcase
        @(negedge clk);
        in_valid = 1'b1; mode_sel = m; base_val = b; disp_imm = d; index_val = ix; scale_sel = sh;
        @(posedge clk); #1;
        chk(req, "out_valid", {31'd0, out_valid}, 32'd1);
        chk(req, "mem_addr", mem_addr, ea);
        chk(req, "new_base", new_base, nb);
        chk(req, "base_wr_en", {31'd0, base_wr_en}, {31'd0, wb});
    endtask

    task automatic t_reset();
        rst_n = 1'b0; in_valid = 1'b1; mode_sel = 2'b01;
        base_val = 32'h1234_5678; disp_imm = 12'h010; index_val = 32'h5; scale_sel = 2'd1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "out_valid", {31'd0, out_valid}, 32'd0);
        chk("R1", "base_wr_en", {31'd0, base_wr_en}, 32'd0);
        chk("R1", "mem_addr", mem_addr, 32'd0);
        chk("R1", "new_base", new_base, 32'd0);
        @(negedge clk); rst_n = 1'b1; in_valid = 1'b0;
    endtask

    task automatic t_offset();
        run_op("R2", 2'b00, 32'h0000_1000, 12'h004, 32'h0, 2'd0);
        run_op("R2", 2'b00, 32'h8000_0000, 12'h7FF, 32'hDEAD_BEEF, 2'd3);
    endtask

    task automatic t_pre();
        run_op("R3", 2'b01, 32'h0000_2000, 12'h020, 32'h0, 2'd0);
    endtask

    task automatic t_post();
        run_op("R4", 2'b10, 32'h0000_3000, 12'h008, 32'h0, 2'd0);
    endtask

    task automatic t_scaled();
        for (int s = 0; s < 4; s++)
            run_op("R5", 2'b11, 32'h0001_0000, 12'h000, 32'h0000_0013, 2'(s));
    endtask

    task automatic t_negative_disp();
        run_op("R6", 2'b00, 32'h0000_1000, 12'hFFF, 32'h0, 2'd0);
        run_op("R6", 2'b01, 32'h0000_1000, 12'h800, 32'h0, 2'd0);
    endtask

    task automatic t_wrap();
        run_op("R7", 2'b10, 32'hFFFF_FFF0, 12'h020, 32'h0, 2'd0);
        run_op("R7", 2'b00, 32'h0000_0100, 12'h800, 32'h0, 2'd0);
        run_op("R7", 2'b11, 32'hFFFF_FFFF, 12'h000, 32'h4000_0001, 2'd2);
    endtask

    task automatic t_back_to_back();
        run_op("R8", 2'b01, 32'h0000_0400, 12'h010, 32'h0, 2'd0);
        run_op("R8", 2'b10, 32'h0000_0500, 12'h010, 32'h0, 2'd0);
        run_op("R8", 2'b00, 32'h0000_0600, 12'h010, 32'h0, 2'd0);
    endtask

    task automatic t_idle_hold();
        run_op("R9", 2'b01, 32'h0000_7000, 12'h044, 32'h0, 2'd0);
        @(negedge clk);
        in_valid = 1'b0; mode_sel = 2'b01; base_val = 32'hAAAA_0000;
        disp_imm = 12'h123; index_val = 32'h99; scale_sel = 2'd3;
        @(posedge clk); #1;
        chk("R9", "out_valid", {31'd0, out_valid}, 32'd0);
        chk("R9", "base_wr_en", {31'd0, base_wr_en}, 32'd0);
        chk("R9", "mem_addr held", mem_addr, 32'h0000_7044);
        chk("R9", "new_base held", new_base, 32'h0000_7044);
    endtask

    task automatic t_ignored_fields();
        run_op("R10", 2'b00, 32'h0000_0800, 12'h010, 32'hFFFF_FFFF, 2'd3);
        run_op("R10", 2'b01, 32'h0000_0800, 12'h010, 32'h7777_7777, 2'd2);
        run_op("R10", 2'b10, 32'h0000_0800, 12'h010, 32'h1234_0000, 2'd1);
        run_op("R10", 2'b11, 32'h0000_0800, 12'hFFF, 32'h0000_0002, 2'd1);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_offset();
        t_pre();
        t_post();
        t_scaled();
        t_negative_disp();
        t_wrap();
        t_back_to_back();
        t_idle_hold();
        t_ignored_fields();
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule